// File: doc/BRIEF.md
# Cycle-Stealing I/O Channel Processor

This block is a small I/O processor that acts as a slave to a host CPU. It moves data between one byte-wide peripheral and a shared memory of 40-bit words. The CPU never reads the block's registers. It hands over work by leaving a program of command words in memory and then issuing a start command. It learns the outcome from status words that the block writes back to a memory address the CPU chooses.

The block reaches memory by stealing cycles. It raises a request, and an external arbiter grants it one access per grant cycle. On input, the block gathers five bytes from the device, at whatever pace the device sets, into one 40-bit word. It then stores that word in a single write. On output, it reads one word and hands it to the device one byte at a time, first byte first. When the program ends, the block raises an interrupt. The interrupt stays high until the CPU asks for a status report and that report has been written.

Top module: `io_chan_proc`

## Requirements
- R1: While reset is held and right after it, `irq` is 0, `mem_req` is 0, `din_ready` is 0 and `dout_valid` is 0. A status report taken right after reset reads 0x04 (ready only).
- R2: A memory access completes only in a cycle where `mem_req` and `mem_gnt` are both 1. While a request waits without a grant, it stays raised with the same address and direction. An input transfer of n bytes makes exactly ceil(n/5) data writes.
- R3: On input, byte k of a transfer goes into word k/5 at bits [39-8*(k%5) -: 8], so the first byte lands in [39:32]. Each word is written at the start address plus k/5.
- R4: When the byte count is not a multiple of 5, the unfilled low bytes of the last word are written as zero.
- R5: On output, word w is read from the start address plus w. Its bytes go out from [39:32] downward, five per word, and exactly `count` bytes are sent. `dout_data` holds steady while `dout_valid` waits for `dout_ready`.
- R6: A command word holds opcode [39:38], chain flag [37], start address [36:16] and byte count [15:0]. Opcode 0 moves device bytes to memory, 1 moves memory to the device, and 2 or 3 halts. Command words are fetched from consecutive addresses. The program stops after a halt, or after a word whose chain flag is 0.
- R7: On the command port, `cmd_op` 1 is test path, 2 is start (with `cmd_addr` giving the program address) and 3 is read status. For test path and read status, `cmd_addr` gives the address where the status word is written.
- R8: Status word bits are: [0] overload, [1] busy (program running), [2] ready (no program running), [3] last program completed normally, [4] last program ended in error. All other bits are 0.
- R9: `irq` rises when a program ends. It falls only after a status write requested by read status has been granted. A test path leaves it high.
- R10: A start command that arrives while a program runs is rejected and leaves the running transfer intact. It sets the overload bit, which appears in the next status word written and is then cleared.
- R11: If the device makes no handshake for TMO consecutive cycles during a byte transfer, the program ends with the error bit set and the completed bit clear, and `irq` still rises. The next start clears the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe from the CPU |
| cmd_op | input | 2 | Command code: 1 test path, 2 start, 3 read status |
| cmd_addr | input | AW | Program address (start) or status address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | 40 | Write data |
| mem_gnt | input | 1 | Arbiter grant; the access happens in this cycle |
| mem_rdata | input | 40 | Read data, valid the cycle after a read grant |
| din_valid | input | 1 | Device has an input byte |
| din_ready | output | 1 | Block takes an input byte |
| din_data | input | 8 | Input byte |
| dout_valid | output | 1 | Block offers an output byte |
| dout_ready | input | 1 | Device takes the output byte |
| dout_data | output | 8 | Output byte |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
Input transfers are swept over byte counts 1 to 12. This covers counts below one word, exactly one and two words, and every partial tail, which separates the byte placement, the zero fill and the count of writes. Output transfers use the same sweep, so off-by-one errors in the word fetch and byte order show up. The device and the arbiter use pseudo-periodic stall patterns throughout. Further short programs separate chained from unchained command words and halts, a rejected start during a running transfer, a stalled device, and status reports taken before and after the interrupt is cleared.

// File: rtl/io_chan_proc.sv
module io_chan_proc #(
  parameter int AW  = 21,
  parameter int CW  = 16,
  parameter int TMO = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [39:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic [39:0]   mem_rdata,
  input  logic          din_valid,
  output logic          din_ready,
  input  logic [7:0]    din_data,
  output logic          dout_valid,
  input  logic          dout_ready,
  output logic [7:0]    dout_data,
  output logic          irq
);
  localparam int TW = $clog2(TMO + 1);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_FWAIT, S_RX, S_WR, S_RD, S_RWAIT, S_TX} st_t;

  st_t           st;
  logic [AW-1:0] pc, addr, stat_addr;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [39:0]   buf_q;
  logic [TW-1:0] tmo;
  logic          chain, ovl, done, err, stat_pend, stat_clr, hold, hold_stat;

  wire eng_req  = (st == S_FETCH) || (st == S_WR) || (st == S_RD);
  wire use_stat = hold ? hold_stat : (stat_pend && !eng_req);
  wire eng_gnt  = mem_gnt && eng_req && !use_stat;
  wire stat_gnt = mem_gnt && use_stat;
  wire [39:0] status = {35'b0, err, done, st == S_IDLE, st != S_IDLE, ovl};
  wire stalled  = (tmo == TW'(TMO - 1));

  assign mem_req    = eng_req || stat_pend;
  assign mem_we     = use_stat || (st == S_WR);
  assign mem_addr   = use_stat ? stat_addr : ((st == S_FETCH) ? pc : addr);
  assign mem_wdata  = use_stat ? status : buf_q;
  assign din_ready  = (st == S_RX);
  assign dout_valid = (st == S_TX);
  assign dout_data  = buf_q[8*(3'd4 - bidx) +: 8];

  wire din_fire  = din_valid && din_ready;
  wire dout_fire = dout_valid && dout_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pc <= '0; addr <= '0; stat_addr <= '0; cnt <= '0; bidx <= '0;
      buf_q <= '0; tmo <= '0; chain <= 1'b0; ovl <= 1'b0; done <= 1'b0; err <= 1'b0;
      stat_pend <= 1'b0; stat_clr <= 1'b0; hold <= 1'b0; hold_stat <= 1'b0; irq <= 1'b0;
    end else begin
      hold      <= mem_req && !mem_gnt;
      hold_stat <= use_stat;
      if (stat_gnt) begin
        stat_pend <= 1'b0; ovl <= 1'b0; stat_clr <= 1'b0;
        if (stat_clr) irq <= 1'b0;
      end
      case (st)
        S_FETCH: if (eng_gnt) begin pc <= pc + AW'(1); st <= S_FWAIT; end
        S_FWAIT: begin
          chain <= mem_rdata[37];
          addr  <= mem_rdata[AW+CW-1:CW];
          cnt   <= mem_rdata[CW-1:0];
          bidx  <= '0; buf_q <= '0; tmo <= '0;
          if (mem_rdata[39]) begin st <= S_IDLE; irq <= 1'b1; done <= 1'b1; end
          else if (mem_rdata[CW-1:0] == '0) begin
            if (mem_rdata[37]) st <= S_FETCH;
            else begin st <= S_IDLE; irq <= 1'b1; done <= 1'b1; end
          end else st <= mem_rdata[38] ? S_RD : S_RX;
        end
        S_RX: begin
          if (din_fire) begin
            buf_q[8*(3'd4 - bidx) +: 8] <= din_data;
            cnt <= cnt - CW'(1); tmo <= '0;
            if (bidx == 3'd4 || cnt == CW'(1)) st <= S_WR;
            else bidx <= bidx + 3'd1;
          end else if (stalled) begin st <= S_IDLE; irq <= 1'b1; err <= 1'b1; end
          else tmo <= tmo + TW'(1);
        end
        S_WR: if (eng_gnt) begin
          addr <= addr + AW'(1); buf_q <= '0; bidx <= '0; tmo <= '0;
          if (cnt != '0) st <= S_RX;
          else if (chain) st <= S_FETCH;
          else begin st <= S_IDLE; irq <= 1'b1; done <= 1'b1; end
        end
        S_RD: if (eng_gnt) st <= S_RWAIT;
        S_RWAIT: begin
          buf_q <= mem_rdata; addr <= addr + AW'(1); bidx <= '0; tmo <= '0; st <= S_TX;
        end
        S_TX: begin
          if (dout_fire) begin
            cnt <= cnt - CW'(1); tmo <= '0;
            if (cnt == CW'(1)) begin
              if (chain) st <= S_FETCH;
              else begin st <= S_IDLE; irq <= 1'b1; done <= 1'b1; end
            end else if (bidx == 3'd4) st <= S_RD;
            else bidx <= bidx + 3'd1;
          end else if (stalled) begin st <= S_IDLE; irq <= 1'b1; err <= 1'b1; end
          else tmo <= tmo + TW'(1);
        end
        default: ;
      endcase
      if (cmd_valid) begin
        if (cmd_op == 2'd1 || cmd_op == 2'd3) begin
          stat_pend <= 1'b1;
          if (!stat_pend || stat_gnt) stat_addr <= cmd_addr;
          if (cmd_op == 2'd3) stat_clr <= 1'b1;
        end else if (cmd_op == 2'd2) begin
          if (st == S_IDLE) begin pc <= cmd_addr; st <= S_FETCH; done <= 1'b0; err <= 1'b0; end
          else ovl <= 1'b1;
        end
      end
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(mem_gnt && use_stat));

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (st == S_IDLE));

  // R5
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (!dout_valid || $stable(dout_data)));

  // R3
  bidx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX || st == S_TX) |-> (bidx <= 3'd4));
endmodule

// File: tb/tb_io_chan_proc.sv
module tb_io_chan_proc;
  localparam int AW = 21, CW = 16, TMO = 32;
  localparam logic [39:0] SENT = 40'hAAAAAAAAAA;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic          mem_req, mem_we, mem_gnt;
  logic [AW-1:0] mem_addr;
  logic [39:0]   mem_wdata, mem_rdata;
  logic          din_valid, din_ready, dout_valid, dout_ready, irq;
  logic [7:0]    din_data, dout_data;

  io_chan_proc #(.AW(AW), .CW(CW), .TMO(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .din_valid(din_valid), .din_ready(din_ready),
    .din_data(din_data), .dout_valid(dout_valid), .dout_ready(dout_ready),
    .dout_data(dout_data), .irq(irq));

  function automatic logic [7:0] fb(input int k); return 8'((k * 37 + 5) % 256); endfunction
  function automatic logic [7:0] gb(input int k); return 8'((k * 53 + 11) % 256); endfunction
  function automatic logic [39:0] cw(input int op, input int ch, input int ad, input int ct);
    return {2'(op), 1'(ch), 21'(ad), 16'(ct)};
  endfunction
  function automatic logic [39:0] pack(input int n, input int w);
    logic [39:0] r = '0;
    for (int j = 0; j < 5; j++) if (w * 5 + j < n) r[8*(4-j) +: 8] = fb(w * 5 + j);
    return r;
  endfunction
  function automatic logic [39:0] outw(input int w);
    logic [39:0] r = '0;
    for (int j = 0; j < 5; j++) r[8*(4-j) +: 8] = gb(w * 5 + j);
    return r;
  endfunction

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [39:0] mem [64];
  int wr_cnt = 0;
  assign mem_gnt = mem_req && ((cyc % 3) != 2);
  always @(posedge clk)
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr[5:0]] <= mem_wdata;
        if (mem_addr < 56) wr_cnt <= wr_cnt + 1;
      end else mem_rdata <= mem[mem_addr[5:0]];
    end

  logic src_en = 1'b0;
  int src_n = 0, src_idx = 0;
  assign din_valid = src_en && (src_idx < src_n) && ((cyc % 3) != 1);
  assign din_data  = fb(src_idx);
  always @(posedge clk) if (din_valid && din_ready) src_idx <= src_idx + 1;

  logic snk_en = 1'b0;
  logic [7:0] snk [64];
  int snk_cnt = 0;
  assign dout_ready = snk_en && ((cyc % 4) != 2);
  always @(posedge clk)
    if (dout_valid && dout_ready) begin snk[snk_cnt % 64] <= dout_data; snk_cnt <= snk_cnt + 1; end

  int nchk = 0, nfail = 0;
  task automatic chk(input string r, input logic [39:0] act, input logic [39:0] exp);
    nchk++;
    if (act !== exp) begin nfail++; $display("FAIL %s actual=%h expected=%h", r, act, exp); end
  endtask

  task automatic cmd(input int op, input int a);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'(op); cmd_addr = AW'(a);
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic wait_irq(input string r);
    int k = 0;
    while (!irq && k < 3000) begin @(negedge clk); k++; end
    chk({r, " irq raised"}, 40'(irq), 40'd1);
  endtask

  task automatic status(input int op, input int a, input string r, input logic [39:0] exp);
    mem[a] <= '0;
    cmd(op, a);
    repeat (10) @(negedge clk);
    chk(r, mem[a], exp);
  endtask

  task automatic fill_sent();
    for (int i = 8; i < 56; i++) mem[i] <= SENT;
  endtask

  initial begin
    #(20 * 150000);
    nfail++; $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] <= '0;
    repeat (4) @(negedge clk);
    chk("R1 irq in reset", 40'(irq), 0);
    chk("R1 req/handshake in reset", {37'b0, mem_req, din_ready, dout_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {36'b0, irq, mem_req, din_ready, dout_valid}, 0);
    status(1, 61, "R1 R7 status after reset", 40'h04);

    // input sweep
    for (int n = 1; n <= 12; n++) begin
      fill_sent();
      mem[8] <= cw(0, 0, 16, n);
      src_idx <= 0; src_n = n; src_en = 1'b1; wr_cnt <= 0;
      cmd(2, 8);
      wait_irq("R9 input");
      for (int w = 0; w < 4; w++)
        chk((n % 5 != 0 && w == (n - 1) / 5) ? "R4 tail word" : "R3 packed word",
            mem[16 + w], (w < (n + 4) / 5) ? pack(n, w) : SENT);
      chk("R2 write count", 40'(wr_cnt), 40'((n + 4) / 5));
      chk("R3 bytes taken", 40'(src_idx), 40'(n));
      status(1, 61, "R8 status after input", 40'h0C);
      chk("R9 irq kept by test path", 40'(irq), 1);
      status(3, 60, "R7 read status", 40'h0C);
      chk("R9 irq cleared", 40'(irq), 0);
      src_en = 1'b0;
    end

    // output sweep
    for (int n = 1; n <= 12; n++) begin
      fill_sent();
      for (int w = 0; w < 3; w++) mem[24 + w] <= outw(w);
      mem[8] <= cw(1, 0, 24, n);
      snk_cnt <= 0; snk_en = 1'b1;
      cmd(2, 8);
      wait_irq("R9 output");
      repeat (4) @(negedge clk);
      chk("R5 bytes sent", 40'(snk_cnt), 40'(n));
      for (int k = 0; k < n; k++) chk("R5 byte value", 40'(snk[k]), 40'(gb(k)));
      status(3, 60, "R8 status after output", 40'h0C);
      snk_en = 1'b0;
    end

    // chained program ending in halt
    fill_sent();
    for (int w = 0; w < 2; w++) mem[24 + w] <= outw(w);
    mem[40] <= cw(0, 1, 16, 3); mem[41] <= cw(1, 1, 24, 7);
    mem[42] <= cw(2, 0, 0, 0);  mem[43] <= cw(0, 0, 30, 5);
    src_idx <= 0; src_n = 8; src_en = 1'b1; snk_cnt <= 0; snk_en = 1'b1;
    cmd(2, 40);
    wait_irq("R6 chain");
    repeat (4) @(negedge clk);
    chk("R6 first word ran", mem[16], pack(3, 0));
    chk("R6 second word ran", 40'(snk_cnt), 7);
    chk("R6 halt stops fetch", mem[30], SENT);
    chk("R6 halt stops input", 40'(src_idx), 3);
    status(3, 60, "R6 status", 40'h0C);

    // chain flag clear stops after one word
    fill_sent();
    mem[24] <= outw(0);
    mem[40] <= cw(1, 0, 24, 2); mem[41] <= cw(0, 0, 16, 5);
    src_idx <= 0; snk_cnt <= 0;
    cmd(2, 40);
    wait_irq("R6 no chain");
    repeat (6) @(negedge clk);
    chk("R6 unchained bytes", 40'(snk_cnt), 2);
    chk("R6 next word skipped", mem[16], SENT);
    status(3, 60, "R6 unchained status", 40'h0C);
    snk_en = 1'b0;

    // rejected start while running
    fill_sent();
    mem[8] <= cw(0, 0, 16, 12); mem[0] <= cw(1, 0, 24, 5);
    src_idx <= 0; src_n = 12; src_en = 1'b1;
    mem[61] <= '0;
    cmd(2, 8);
    cmd(2, 0);
    cmd(1, 61);
    repeat (6) @(negedge clk);
    chk("R10 overload and busy", mem[61], 40'h03);
    wait_irq("R10 run");
    for (int w = 0; w < 3; w++) chk("R10 transfer intact", mem[16 + w], pack(12, w));
    status(3, 60, "R10 overload cleared", 40'h0C);

    // device stall
    fill_sent();
    src_en = 1'b0;
    mem[8] <= cw(0, 0, 16, 5);
    cmd(2, 8);
    wait_irq("R11 stall");
    chk("R11 nothing written", mem[16], SENT);
    status(3, 60, "R11 error status", 40'h14);
    src_idx <= 0; src_n = 5; src_en = 1'b1;
    cmd(2, 8);
    wait_irq("R11 rerun");
    chk("R11 rerun data", mem[16], pack(5, 0));
    status(3, 60, "R11 error cleared", 40'h0C);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule